// File: doc/BRIEF.md
# Slot Ring Handoff Controller

This block sequences a circular set of buffer slots between an asynchronous filler and a consumer. The producer side is offered a slot index and lap bit; once the offer is accepted the filler moves data into that slot on its own schedule and reports completion with the slot number. The consumer side is told which slot is next and whether its contents have arrived. It releases the slot once it has used it, and the controller then moves on to the following slot, wrapping after the last one.

Each slot carries two phase bits of its own: one flips when a fill lands, the other when the consumer hands the slot back. The two sides each hold an index and a lap parity, and each waits only on the phase bit of the slot it needs. No barrier covers the whole ring, so the filler can run up to a whole ring ahead of a slow consumer. A fast consumer just waits on the next slot.

A run begins with a start pulse that loads the number of tiles. Consumption is held back until a prologue has issued one fewer fill than there are slots, or all tiles if there are fewer. The producer stops offering once every tile has been issued. The consumer drains the remaining slots, and the block then raises done. Slot storage and the data itself live outside the block.

Top module: `ring_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, issue_valid and cons_valid are all 0.
- R2: With busy at 0, a start pulse loads total_tiles and raises busy on the next cycle. A start pulse while busy is 1 is ignored, and so is the total_tiles value that comes with it.
- R3: The producer is offered slots in the order 0, 1, ..., NUM_SLOTS-1, 0, ... across runs. issue_lap begins at 0 and inverts each time the offered index wraps back to 0. An offer is taken in a cycle when issue_valid and issue_ready are both 1.
- R4: During a run, cons_valid stays 0 until min(NUM_SLOTS-1, total) offers have been taken.
- R5: The consumer is presented slots in the same wrapping order, with cons_lap inverting on wrap. cons_valid is 1 exactly when the presented slot's fill has completed for the current lap. Fills may complete out of order.
- R6: A fill_done naming a slot that has no accepted, still-unfilled offer has no effect.
- R7: cons_release while cons_valid is 0 has no effect. A release taken while cons_valid is 1 frees the slot and advances the consumer.
- R8: Once total offers have been taken in a run, issue_valid stays 0 for the rest of the run.
- R9: Done rises and busy falls one cycle after the release that brings the released count to total. With a total of 0 this happens one cycle after start. Done stays 1 until the next accepted start.
- R10: While issue_valid is 1 and issue_ready is 0, issue_valid stays 1 and issue_slot keeps its value.
- R11: A slot is offered again only after it has been released. Offered-but-unreleased slots never number more than NUM_SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| total_tiles | input | CNT_W | Tile count for the run |
| issue_valid | output | 1 | A slot is free for a fill |
| issue_ready | input | 1 | Filler accepts the offered slot |
| issue_slot | output | SLOT_W | Offered slot index |
| issue_lap | output | 1 | Producer lap parity |
| fill_done | input | 1 | A fill has landed |
| fill_slot | input | SLOT_W | Slot whose fill has landed |
| cons_valid | output | 1 | Presented slot holds data |
| cons_slot | output | SLOT_W | Slot presented to the consumer |
| cons_lap | output | 1 | Consumer lap parity |
| cons_release | input | 1 | Consumer hands the presented slot back |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |

## Verification
Short directed runs with totals of 0, 1, 2, NUM_SLOTS-1 and NUM_SLOTS check the prologue limit and drain at their edges. In these runs min(NUM_SLOTS-1, total) changes which term wins. Random runs vary how willing the filler, the fill completions and the consumer are. A slow consumer with a fast filler drives the ring full and shows the reuse guard and lap bits. Slow, out-of-order completions with a fast consumer show that readiness is tracked per slot and not in issue order. Spurious completions, releases and starts are mixed in, and a cycle-exact model confirms that each one changes nothing.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int MIN_SLOTS = 3;
  localparam int MAX_SLOTS = 8;

  function automatic int slot_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [SW-1:0] idx,
  output logic          lap
);
  localparam logic [SW-1:0] LAST = SW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      lap <= 1'b0;
    end else if (adv) begin
      if (idx == LAST) begin
        idx <= '0;
        lap <= ~lap;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ring_phase_bank.sv
module ring_phase_bank #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [SW-1:0] sel,
  output logic [N-1:0]  ph
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)
        bit_q <= 1'b0;
      else if (hit && sel == SW'(g))
        bit_q <= ~bit_q;
    end
    assign ph[g] = bit_q;
  end
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl #(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 16,
  parameter int SLOT_W    = ring_pkg::slot_bits(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  total_tiles,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [SLOT_W-1:0] issue_slot,
  output logic              issue_lap,
  input  logic              fill_done,
  input  logic [SLOT_W-1:0] fill_slot,
  output logic              cons_valid,
  output logic [SLOT_W-1:0] cons_slot,
  output logic              cons_lap,
  input  logic              cons_release,
  output logic              busy,
  output logic              done
);
  localparam logic [CNT_W-1:0] PRO_FILLS = CNT_W'(NUM_SLOTS - 1);
  localparam logic [SLOT_W:0]  SLOT_CNT  = (SLOT_W + 1)'(NUM_SLOTS);

  logic              active_q, done_q;
  logic [CNT_W-1:0]  total_q, issued_q, released_q;
  logic [SLOT_W-1:0] pidx, cidx;
  logic              plap, clap;
  logic [NUM_SLOTS-1:0] full_ph, empty_ph, pend;
  logic [CNT_W-1:0]  pro_lim;
  logic              in_prologue, issue_fire, cons_fire, fill_ok;

  assign pro_lim     = (total_q < PRO_FILLS) ? total_q : PRO_FILLS;
  assign in_prologue = issued_q < pro_lim;

  assign issue_valid = active_q && (issued_q != total_q) && (empty_ph[pidx] == plap);
  assign cons_valid  = active_q && !in_prologue && (full_ph[cidx] != clap);
  assign issue_fire  = issue_valid && issue_ready;
  assign cons_fire   = cons_valid && cons_release;
  assign fill_ok     = fill_done && ({1'b0, fill_slot} < SLOT_CNT) && pend[fill_slot];

  assign issue_slot = pidx;
  assign issue_lap  = plap;
  assign cons_slot  = cidx;
  assign cons_lap   = clap;
  assign busy       = active_q;
  assign done       = done_q;

  ring_ptr #(.N(NUM_SLOTS), .SW(SLOT_W)) u_prod_ptr (
    .clk(clk), .rst(rst), .adv(issue_fire), .idx(pidx), .lap(plap)
  );

  ring_ptr #(.N(NUM_SLOTS), .SW(SLOT_W)) u_cons_ptr (
    .clk(clk), .rst(rst), .adv(cons_fire), .idx(cidx), .lap(clap)
  );

  ring_phase_bank #(.N(NUM_SLOTS), .SW(SLOT_W)) u_full_bank (
    .clk(clk), .rst(rst), .hit(fill_ok), .sel(fill_slot), .ph(full_ph)
  );

  ring_phase_bank #(.N(NUM_SLOTS), .SW(SLOT_W)) u_empty_bank (
    .clk(clk), .rst(rst), .hit(cons_fire), .sel(cidx), .ph(empty_ph)
  );

  // Outstanding-fill marker per slot: set on accepted offer, cleared on landing
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_pend
    logic pend_q;
    always_ff @(posedge clk) begin
      if (rst)
        pend_q <= 1'b0;
      else if (issue_fire && pidx == SLOT_W'(g))
        pend_q <= 1'b1;
      else if (fill_ok && fill_slot == SLOT_W'(g))
        pend_q <= 1'b0;
    end
    assign pend[g] = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      done_q     <= 1'b0;
      total_q    <= '0;
      issued_q   <= '0;
      released_q <= '0;
    end else if (!active_q) begin
      if (start) begin
        active_q   <= 1'b1;
        done_q     <= 1'b0;
        total_q    <= total_tiles;
        issued_q   <= '0;
        released_q <= '0;
      end
    end else begin
      if (issue_fire) issued_q <= issued_q + 1'b1;
      if (cons_fire)  released_q <= released_q + 1'b1;
      if (released_q == total_q) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ring_ctrl_chk.sv
module ring_ctrl_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 16,
  parameter int SLOT_W    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic [SLOT_W-1:0] issue_slot,
  input logic              cons_valid,
  input logic              cons_release,
  input logic [SLOT_W-1:0] cons_slot,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  issued_q,
  input logic [CNT_W-1:0]  released_q
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  p_issue_step_r3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_ready) |=>
      issue_slot == (($past(issue_slot) == LAST) ? '0 : $past(issue_slot) + 1'b1));

  p_cons_step_r5: assert property (@(posedge clk) disable iff (rst)
    (cons_valid && cons_release) |=>
      cons_slot == (($past(cons_slot) == LAST) ? '0 : $past(cons_slot) + 1'b1));

  p_cons_has_data_r5: assert property (@(posedge clk) disable iff (rst)
    cons_valid |-> (busy && issued_q > released_q));

  p_release_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    !cons_valid |=> $stable(cons_slot));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_offer_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_ready) |=> (issue_valid && $stable(issue_slot)));

  p_inflight_bound_r11: assert property (@(posedge clk) disable iff (rst)
    (issued_q - released_q) <= CNT_W'(NUM_SLOTS));
endmodule

bind ring_ctrl ring_ctrl_chk #(
  .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
) u_ring_ctrl_chk (
  .clk(clk), .rst(rst),
  .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_slot(issue_slot),
  .cons_valid(cons_valid), .cons_release(cons_release), .cons_slot(cons_slot),
  .busy(busy), .done(done),
  .issued_q(issued_q), .released_q(released_q)
);

// File: tb/test_ring_ctrl.sv
module test_ring_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 5;
  localparam int CW = 16;
  localparam int SW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [CW-1:0] total_tiles;
  logic          issue_valid, issue_ready, issue_lap;
  logic [SW-1:0] issue_slot;
  logic          fill_done;
  logic [SW-1:0] fill_slot;
  logic          cons_valid, cons_lap, cons_release;
  logic [SW-1:0] cons_slot;
  logic          busy, done;

  ring_ctrl #(.NUM_SLOTS(NB), .CNT_W(CW)) i_ring_ctrl (
    .clk(clk), .rst(rst), .start(start), .total_tiles(total_tiles),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_slot(issue_slot), .issue_lap(issue_lap),
    .fill_done(fill_done), .fill_slot(fill_slot),
    .cons_valid(cons_valid), .cons_slot(cons_slot), .cons_lap(cons_lap),
    .cons_release(cons_release), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit wd = 0;

  // Reference model state
  bit e_busy = 0, e_done = 0, e_pl = 0, e_cl = 0;
  int e_T = 0, e_iss = 0, e_rel = 0, e_ps = 0, e_cs = 0;
  bit pend [NB];
  bit full [NB];
  bit last_hold = 0, last_bogus_fill = 0, last_ign_rel = 0;

  function automatic int nxt(input int s);
    return (s == NB - 1) ? 0 : s + 1;
  endfunction

  function automatic int pro_lim(input int t);
    return (t < NB - 1) ? t : NB - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  task automatic step(input bit do_start, input int t, input int p_rdy,
                      input int p_rel, input int p_fill, input int p_bs);
    bit exp_iv, exp_cv, go_done, st;
    string iv_tag, cv_tag;
    int r;
    @(negedge clk);
    cycles++;
    exp_iv = e_busy && (e_iss != e_T) && !pend[e_ps] && !full[e_ps];
    exp_cv = e_busy && (e_iss >= pro_lim(e_T)) && full[e_cs];

    chk("R2 busy", busy, e_busy);
    chk("R9 done", done, e_done);
    if (e_busy && e_iss == e_T)               iv_tag = "R8 issue_valid after count";
    else if (e_busy && (pend[e_ps] || full[e_ps])) iv_tag = "R11 issue_valid on occupied slot";
    else if (last_hold)                       iv_tag = "R10 issue_valid held";
    else                                      iv_tag = "R3 issue_valid";
    chk(iv_tag, issue_valid, exp_iv);
    if (exp_iv) begin
      chk(last_hold ? "R10 issue_slot held" : "R3 issue_slot", issue_slot, e_ps);
      chk("R3 issue_lap", issue_lap, e_pl);
    end
    if (e_busy && e_iss < pro_lim(e_T)) cv_tag = "R4 cons_valid in prologue";
    else if (last_bogus_fill)           cv_tag = "R6 cons_valid after spurious fill";
    else if (last_ign_rel)              cv_tag = "R7 cons_valid after ignored release";
    else                                cv_tag = "R5 cons_valid";
    chk(cv_tag, cons_valid, exp_cv);
    if (exp_cv) begin
      chk(last_ign_rel ? "R7 cons_slot" : "R5 cons_slot", cons_slot, e_cs);
      chk("R5 cons_lap", cons_lap, e_cl);
    end

    // Drive inputs for the next edge
    issue_ready  = ($urandom % 100) < p_rdy;
    cons_release = ($urandom % 100) < p_rel;
    fill_done    = 1'b0;
    fill_slot    = '0;
    r = -1;
    if (($urandom % 100) < p_fill) begin
      r = $urandom % NB;
      fill_done = 1'b1;
      fill_slot = SW'(r);
    end
    st = do_start || (e_busy && (($urandom % 100) < p_bs));
    start = st;
    total_tiles = do_start ? CW'(t) : CW'($urandom % 50);

    // Model update for the coming edge
    go_done = e_busy && (e_rel == e_T);
    last_hold = exp_iv && !issue_ready;
    last_bogus_fill = fill_done && !pend[r < 0 ? 0 : r];
    last_ign_rel = cons_release && !exp_cv;
    if (r >= 0 && pend[r]) begin
      pend[r] = 0;
      full[r] = 1;
    end
    if (cons_release && exp_cv) begin
      full[e_cs] = 0;
      if (e_cs == NB - 1) e_cl = !e_cl;
      e_cs = nxt(e_cs);
      e_rel++;
    end
    if (issue_ready && exp_iv) begin
      pend[e_ps] = 1;
      if (e_ps == NB - 1) e_pl = !e_pl;
      e_ps = nxt(e_ps);
      e_iss++;
    end
    if (st && !e_busy) begin
      e_busy = 1; e_done = 0; e_T = t; e_iss = 0; e_rel = 0;
    end else if (go_done) begin
      e_busy = 0; e_done = 1;
    end
  endtask

  task automatic run(input int t, input int p_rdy, input int p_rel,
                     input int p_fill, input int p_bs);
    if (wd) return;
    step(1, t, p_rdy, p_rel, p_fill, p_bs);
    while (e_busy && !wd) begin
      step(0, 0, p_rdy, p_rel, p_fill, p_bs);
      if (cycles > 150000) wd = 1;
    end
    repeat (3) step(0, 0, 50, 50, 40, 0);  // idle: spurious fills/releases
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) begin pend[i] = 0; full[i] = 0; end
    rst = 1; start = 0; total_tiles = '0; issue_ready = 0;
    fill_done = 0; fill_slot = '0; cons_release = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 issue_valid in reset", issue_valid, 0);
    chk("R1 cons_valid in reset", cons_valid, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 issue_valid after reset", issue_valid, 0);
    chk("R1 cons_valid after reset", cons_valid, 0);

    // Directed corners around the prologue limit
    run(0, 100, 100, 100, 0);
    run(1, 100, 100, 100, 0);
    run(2, 80, 80, 80, 0);
    run(NB - 1, 100, 100, 100, 0);
    run(NB, 100, 100, 100, 0);
    // Ring full: eager filler, lazy consumer
    run(40, 100, 8, 90, 5);
    // Lazy, scattered fills against an eager consumer
    run(40, 90, 100, 15, 5);
    // Back-pressured filler
    run(30, 10, 90, 80, 5);
    for (int k = 0; k < 12; k++)
      run(10 + ($urandom % 60), 10 + ($urandom % 90), 10 + ($urandom % 90),
          10 + ($urandom % 90), 5);

    if (wd) begin
      checks++; fails++;
      $display("FAIL R9 watchdog: run never finished actual=busy expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule